// File: doc/BRIEF.md
# Set/Clear Aliased Flag Register Bank

This block holds two flag words behind a small memory-mapped bus. The first is a general-purpose flag word. The second models flags that survive a system reset. Neither word has a plain write path. Each word has two bus addresses. A write to the lower address ORs the written data into the word, and a read from that same address returns the word. A write to the address one word above clears every bit that is 1 in the written data.

Software that wants to load an exact value into a word makes two writes. First it writes all ones to the clear address, then it writes the value to the set address. Because every update touches only the bits marked in the data, independent agents can own separate bits without a read-modify-write sequence.

The two words differ only in how they reset. The general word clears on either the ordinary reset or the power-on reset. By default the persistent word listens only to the power-on reset. A parameter can make it follow the ordinary reset as well. Reads are combinational, so a value written in one cycle can be read back in the next.

Top module: `flag_alias_bank`

## Requirements
- R1: A write to byte offset 0x30 sets every general-word bit that is 1 in the data and leaves the bits where the data is 0 unchanged. A read from 0x30 returns the general word.
- R2: A write to byte offset 0x34 clears every general-word bit that is 1 in the data and leaves the other bits unchanged.
- R3: The persistent word is read and bit-set at offset 0x38 and bit-cleared at offset 0x3C, with the same per-bit rules as R1 and R2. Accesses to one word never change the other.
- R4: A write of all ones to a clear address, followed by a write of value V to the matching set address, leaves exactly V in that word.
- R5: A read in the cycle immediately after an accepted write returns the updated word.
- R6: The general word becomes 0 at a clock edge where rst_n or por_n is low (synchronous, active low).
- R7: With the default parameters, the persistent word keeps its value while rst_n is low. It becomes 0 at a clock edge where por_n is low.
- R8: A read from a clear address (0x34 or 0x3C) returns 0.
- R9: A write to any offset other than 0x30, 0x34, 0x38 or 0x3C changes neither word, including unaligned offsets. A read from such an offset returns 0.
- R10: bus_rdata is 0 in any cycle without a read (bus_sel low, or bus_we high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Ordinary synchronous reset, active low |
| por_n | input | 1 | Power-on synchronous reset, active low; clears both words |
| bus_sel | input | 1 | Access valid in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; 1 bits mark the bits to set or clear |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |

## Verification
A corrupted flag word can only be seen through a read of its set address. Because reads are combinational, a wrong update becomes visible in the cycle right after the faulty write, provided the next access reads that word. The bench therefore alternates writes with reads and keeps a bit-accurate model of both words. A reset-policy fault on the persistent word is hidden until a reset pulse occurs, so the bench reads both words right after separate ordinary and power-on reset pulses.

// File: rtl/flag_alias_pkg.sv
// Shared types for the set/clear aliased flag bank.
// Assumes one bus access per cycle, so a word never sees set and clear together.
package flag_alias_pkg;

    // Per-word decode result for the current bus cycle.
    typedef struct packed {
        logic rd_val;   // read of the word's set/read address
        logic set_en;   // write to the word's set address
        logic clr_en;   // write to the word's clear address
    } word_hit_t;

endpackage

// File: rtl/flag_alias_decode.sv
// Address decoder: turns one bus access into per-word set, clear and read strobes.
// Assumes exact byte-offset match. Unaligned or unmapped offsets produce no strobe.
module flag_alias_decode
    import flag_alias_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_WORDS = 2,
    parameter logic [NUM_WORDS*ADDR_W-1:0] BASES = '0
) (
    input  logic                          bus_sel,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    output word_hit_t [NUM_WORDS-1:0]     hits
);
    localparam int STRIDE = DATA_W / 8;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        localparam logic [ADDR_W-1:0] SET_ADDR = BASES[g*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] CLR_ADDR = SET_ADDR + ADDR_W'(STRIDE);

        // Strobes for this word, gated by a valid access.
        always_comb begin
            hits[g].rd_val = bus_sel && !bus_we && (bus_addr == SET_ADDR);
            hits[g].set_en = bus_sel &&  bus_we && (bus_addr == SET_ADDR);
            hits[g].clr_en = bus_sel &&  bus_we && (bus_addr == CLR_ADDR);
        end
    end
endmodule

// File: rtl/flag_alias_word.sv
// One flag word changed only by bit-set and bit-clear strobes.
// USE_SYS_RST selects whether the ordinary reset clears it; power-on reset always does.
module flag_alias_word #(
    parameter int                 DATA_W      = 32,
    parameter logic [DATA_W-1:0]  RST_VAL     = '0,
    parameter bit                 USE_SYS_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic rst_act_n;

    if (USE_SYS_RST) begin : g_both_rst
        // Word follows both the ordinary and the power-on reset.
        assign rst_act_n = rst_n & por_n;
    end else begin : g_por_only
        // Word ignores the ordinary reset.
        logic unused_rst;
        assign unused_rst = rst_n;
        assign rst_act_n  = por_n;
    end

    // Apply the reset, then the set or clear mask, to the stored word.
    always_ff @(posedge clk) begin
        if (!rst_act_n) begin
            q <= RST_VAL;
        end else if (set_en) begin
            q <= q | wdata;
        end else if (clr_en) begin
            q <= q & ~wdata;
        end
    end
endmodule

// File: rtl/flag_alias_rdmux.sv
// Read multiplexer: returns the addressed word, or zero when no word read is active.
// Assumes the decoder raises at most one rd_val per cycle.
module flag_alias_rdmux
    import flag_alias_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 2
) (
    input  word_hit_t [NUM_WORDS-1:0]               hits,
    input  logic      [NUM_WORDS-1:0][DATA_W-1:0]   words,
    output logic      [DATA_W-1:0]                  rdata
);
    // OR together the gated words; zero when nothing is read.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (hits[i].rd_val) begin
                rdata = rdata | words[i];
            end
        end
    end
endmodule

// File: rtl/flag_alias_bank.sv
// Top: two flag words, each behind a set/read address and a clear address.
// Word 0 is general purpose. Word 1 models persistent flags whose reset policy is a parameter.
// Assumes a single-cycle bus with combinational read data.
module flag_alias_bank
    import flag_alias_pkg::*;
#(
    parameter int                ADDR_W          = 8,
    parameter int                DATA_W          = 32,
    parameter logic [ADDR_W-1:0] GEN_BASE        = 8'h30,
    parameter logic [ADDR_W-1:0] NV_BASE         = 8'h38,
    parameter logic [DATA_W-1:0] GEN_RST_VAL     = '0,
    parameter logic [DATA_W-1:0] NV_RST_VAL      = '0,
    parameter bit                NV_ON_SYS_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int NUM_WORDS = 2;
    localparam logic [NUM_WORDS*ADDR_W-1:0] BASES = {NV_BASE, GEN_BASE};

    word_hit_t [NUM_WORDS-1:0]             hits;
    logic      [NUM_WORDS-1:0][DATA_W-1:0] word_vals;

    flag_alias_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_WORDS(NUM_WORDS),
        .BASES    (BASES)
    ) u_decode (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .hits    (hits)
    );

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_words
        localparam bit                USE_SYS = (g == 0) ? 1'b1 : NV_ON_SYS_RESET;
        localparam logic [DATA_W-1:0] RV      = (g == 0) ? GEN_RST_VAL : NV_RST_VAL;

        flag_alias_word #(
            .DATA_W     (DATA_W),
            .RST_VAL    (RV),
            .USE_SYS_RST(USE_SYS)
        ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .por_n (por_n),
            .set_en(hits[g].set_en),
            .clr_en(hits[g].clr_en),
            .wdata (bus_wdata),
            .q     (word_vals[g])
        );
    end

    flag_alias_rdmux #(
        .DATA_W   (DATA_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_rdmux (
        .hits (hits),
        .words(word_vals),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/flag_alias_bank_chk.sv
// Checker for flag_alias_bank: relates bus accesses to the stored words over time.
// Bound to the top so it can observe the word registers directly.
module flag_alias_bank_chk #(
    parameter int                ADDR_W          = 8,
    parameter int                DATA_W          = 32,
    parameter logic [ADDR_W-1:0] GEN_BASE        = 8'h30,
    parameter logic [ADDR_W-1:0] NV_BASE         = 8'h38,
    parameter bit                NV_ON_SYS_RESET = 1'b0
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            por_n,
    input logic                            bus_sel,
    input logic                            bus_we,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_wdata,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic [1:0][DATA_W-1:0]          word_vals
);
    localparam logic [ADDR_W-1:0] GEN_CLR = GEN_BASE + ADDR_W'(DATA_W / 8);
    localparam logic [ADDR_W-1:0] NV_CLR  = NV_BASE  + ADDR_W'(DATA_W / 8);

    logic armed = 1'b0;
    // Enable checks only after the first edge has loaded real values.
    always_ff @(posedge clk) armed <= 1'b1;

    logic wr, rd, gen_touch, nv_touch;
    assign wr        = bus_sel && bus_we;
    assign rd        = bus_sel && !bus_we;
    assign gen_touch = wr && (bus_addr == GEN_BASE || bus_addr == GEN_CLR);
    assign nv_touch  = wr && (bus_addr == NV_BASE  || bus_addr == NV_CLR);

    p_gen_set_r1: assert property (@(posedge clk) disable iff (!armed || !rst_n || !por_n)
        (wr && bus_addr == GEN_BASE) |=> word_vals[0] == ($past(word_vals[0]) | $past(bus_wdata)));

    p_gen_clr_r2: assert property (@(posedge clk) disable iff (!armed || !rst_n || !por_n)
        (wr && bus_addr == GEN_CLR) |=> word_vals[0] == ($past(word_vals[0]) & ~$past(bus_wdata)));

    p_nv_set_r3: assert property (@(posedge clk) disable iff (!armed || !por_n)
        (wr && bus_addr == NV_BASE) |=> word_vals[1] == ($past(word_vals[1]) | $past(bus_wdata)));

    p_gen_reset_r6: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n || !por_n) |=> word_vals[0] == '0);

    p_nv_por_r7: assert property (@(posedge clk) disable iff (!armed)
        !por_n |=> word_vals[1] == '0);

    if (!NV_ON_SYS_RESET) begin : g_nv_hold
        p_nv_keep_r7: assert property (@(posedge clk) disable iff (!armed || !por_n)
            (!rst_n && !nv_touch) |=> $stable(word_vals[1]));
    end

    p_clr_read_zero_r8: assert property (@(posedge clk) disable iff (!armed)
        (rd && (bus_addr == GEN_CLR || bus_addr == NV_CLR)) |-> bus_rdata == '0);

    p_untouched_r9: assert property (@(posedge clk) disable iff (!armed || !rst_n || !por_n)
        !gen_touch |=> $stable(word_vals[0]));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!armed)
        !rd |-> bus_rdata == '0);

    p_read_word_r1: assert property (@(posedge clk) disable iff (!armed)
        (rd && bus_addr == GEN_BASE) |-> bus_rdata == word_vals[0]);
endmodule

bind flag_alias_bank flag_alias_bank_chk #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .GEN_BASE       (GEN_BASE),
    .NV_BASE        (NV_BASE),
    .NV_ON_SYS_RESET(NV_ON_SYS_RESET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .word_vals(word_vals)
);

// File: tb/flag_alias_bank_tb.sv
`timescale 1ns/1ps
module flag_alias_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_gen = '0;
    logic [31:0] m_nv  = '0;

    always #4 clk = ~clk;

    flag_alias_bank u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Reference read value of the behavioural model.
    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h30:   return m_gen;
            8'h38:   return m_nv;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        case (a)
            8'h30: m_gen = m_gen | d;
            8'h34: m_gen = m_gen & ~d;
            8'h38: m_nv  = m_nv | d;
            8'h3C: m_nv  = m_nv & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = $urandom;
        #1;
        check(req, bus_rdata, model_read(a));
        @(posedge clk);
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 8'h30;
        #1;
        check(req, bus_rdata, 32'h0);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h38; bus_wdata = 32'h0;
        #1;
        check(req, bus_rdata, 32'h0);
        bus_sel = 1'b0;
        @(posedge clk);
        m_nv = m_nv | 32'h0;
    endtask

    task automatic pulse_reset(input logic sys, input logic por);
        @(negedge clk);
        bus_sel = 1'b0; rst_n = ~sys; por_n = ~por;
        @(posedge clk);
        if (sys || por) m_gen = '0;
        if (por) m_nv = '0;
        @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    function automatic logic [7:0] pick_addr(input int k);
        case (k)
            0: return 8'h30; 1: return 8'h34; 2: return 8'h38; 3: return 8'h3C;
            4: return 8'h40; 5: return 8'h2C; 6: return 8'h31; default: return 8'h3A;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R6/R7 reset state
        bus_read(8'h30, "R6 reset");
        bus_read(8'h38, "R7 reset");

        // R1 set keeps other bits; R5 readable next cycle
        bus_write(8'h30, 32'h0000_00F0);
        bus_read(8'h30, "R5 read after write");
        bus_write(8'h30, 32'h8000_0001);
        bus_read(8'h30, "R1 set");

        // R2 clear only marked bits
        bus_write(8'h34, 32'h0000_0030);
        bus_read(8'h30, "R2 clear");
        bus_write(8'h34, 32'h0000_0000);
        bus_read(8'h30, "R2 zero clear");

        // R3 persistent word independent of general word
        bus_write(8'h38, 32'h00FF_00FF);
        bus_read(8'h38, "R3 set");
        bus_read(8'h30, "R3 isolation");
        bus_write(8'h3C, 32'h000F_000F);
        bus_read(8'h38, "R3 clear");

        // R4 full overwrite in two writes
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'h1234_5678);
        bus_read(8'h30, "R4 overwrite gen");
        bus_write(8'h3C, 32'hFFFF_FFFF);
        bus_write(8'h38, 32'hCAFE_0001);
        bus_read(8'h38, "R4 overwrite nv");

        // R8 clear aliases read zero
        bus_read(8'h34, "R8 gen clear read");
        bus_read(8'h3C, "R8 nv clear read");

        // R9 unmapped and unaligned writes ignored
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_write(8'h31, 32'hFFFF_FFFF);
        bus_write(8'h3A, 32'hFFFF_FFFF);
        bus_read(8'h30, "R9 gen unchanged");
        bus_read(8'h38, "R9 nv unchanged");
        bus_read(8'h2C, "R9 unmapped read");

        // R10 no read, zero data
        idle_check("R10 idle");

        // R7 persistent word survives ordinary reset; R6 gen cleared
        pulse_reset(1'b1, 1'b0);
        bus_read(8'h30, "R6 sys reset");
        bus_read(8'h38, "R7 keep on sys reset");
        bus_write(8'h30, 32'h0000_0F0F);
        pulse_reset(1'b0, 1'b1);
        bus_read(8'h30, "R6 por reset");
        bus_read(8'h38, "R7 por reset");

        // Mixed random traffic against the model (R1 R2 R3 R9)
        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom % 8;
            if ($urandom % 2 == 0)
                bus_write(pick_addr(k), $urandom & $urandom);
            else
                bus_read(pick_addr(k), "R1 R2 R3 R9 random");
        end

        @(negedge clk);
        bus_sel = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule